// File: doc/BRIEF.md
# Audio receive slot buffer

This block sits behind a serial audio receiver. Each time the receive shift register has collected a complete word, it raises a strobe together with the word and the number of the time slot the word belongs to. A slot-assignment mask chooses where the word goes. A slot whose mask bit is set has its own holding register, which a DMA engine reads. Every other slot feeds one shared FIFO, which the CPU drains one entry at a time through a single read port.

A sample-size input selects 8-bit or 16-bit samples. In 16-bit mode the whole word is stored. In 8-bit mode only the low byte is kept, and the stored high byte is forced to zero. The bus side is read-only. The block reports whether the FIFO is full or empty. It also keeps a sticky overrun flag, which records a word that was lost because it arrived while the FIFO was full.

Top module: `audio_rx_slot_buf`

## Requirements
- R1: In 16-bit mode (`mode_wide`=1), a strobed word whose slot bit in `slot_dma_map` is 0 enters the FIFO unchanged. FIFO entries are read back in arrival order.
- R2: In 8-bit mode (`mode_wide`=0), a stored word keeps bits 7:0 of `rx_word` and has bits 15:8 set to zero. This holds for both the FIFO and the DMA registers.
- R3: A strobed word whose slot has its `slot_dma_map` bit set to 1 is written only into the DMA register of that slot. The FIFO is not touched.
- R4: All DMA registers read zero after reset. `dma_rdata` shows the register chosen by `dma_sel` one clock after `dma_sel` is applied.
- R5: A one-cycle `fifo_rd` pulse while the FIFO is not empty places the oldest entry on `fifo_rdata` one clock later and removes that entry.
- R6: A `fifo_rd` pulse while the FIFO is empty leaves `fifo_rdata` at its last value, and the FIFO stays empty.
- R7: After reset, `fifo_empty`=1 and `fifo_full`=0. `fifo_full` is 1 exactly when DEPTH entries are held, and `fifo_empty` is 1 exactly when none are held.
- R8: A word headed for the FIFO while it is full is dropped, and `overrun` is set. `overrun` then stays at 1.
- R9: A `ovr_clr` pulse clears `overrun`. If a drop happens in the same cycle as the clear, the set takes priority.
- R10: Without `rx_full_strobe`, changes on `rx_word` and `rx_slot` store nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wide | input | 1 | 1 = 16-bit samples, 0 = 8-bit samples |
| slot_dma_map | input | NUM_SLOTS | Bit n = 1 sends slot n to its DMA register |
| rx_full_strobe | input | 1 | Shift register holds a complete word |
| rx_slot | input | log2(NUM_SLOTS) | Slot number of the strobed word |
| rx_word | input | SAMPLE_W | Word from the shift register |
| fifo_rd | input | 1 | Pop one FIFO entry |
| fifo_rdata | output | SAMPLE_W | Last popped FIFO entry |
| fifo_full | output | 1 | FIFO holds DEPTH entries |
| fifo_empty | output | 1 | FIFO holds no entry |
| overrun | output | 1 | Sticky: a FIFO-bound word was dropped |
| ovr_clr | input | 1 | Clear the overrun flag |
| dma_sel | input | log2(NUM_SLOTS) | DMA register to read |
| dma_rdata | output | SAMPLE_W | Contents of the selected DMA register |

## Verification
The hardest case to reach is a drop that lands in the same cycle as an overrun clear. This requires a full FIFO and a strobe to a slot not assigned to DMA, together with `ovr_clr`. The stimulus fills the FIFO to DEPTH entries through one non-DMA slot and then applies the extra strobe and the clear in the same cycle. A scoreboard queue models which words should survive the drop, and a monitor compares every popped entry against that queue.

// File: rtl/arx_pkg.sv
package arx_pkg;
  localparam int BYTE_W = 8;
  typedef enum logic {SMP_8BIT = 1'b0, SMP_16BIT = 1'b1} smp_mode_e;
endpackage

// File: rtl/arx_fifo.sv
module arx_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          wr_ok, rd_ok;

  assign full  = (cnt == FULL_CNT);
  assign empty = (cnt == '0);
  assign wr_ok = wr_en && !full;
  assign rd_ok = rd_en && !empty;

  initial assert (DEPTH >= 4 && (DEPTH & (DEPTH - 1)) == 0)
    else $error("DEPTH must be a power of two, at least 4");

  // Storage without reset, so it can map to block RAM.
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_ok) rd_data <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr_ok) wp <= wp + 1'b1;
      if (rd_ok) rp <= rp + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assert_drop_keeps_count_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full && !rd_en) |=> (cnt == $past(cnt)));
  assert_empty_read_holds_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && empty && !wr_en) |=> ($stable(rd_data) && empty));
  assert_count_bound_R7: assert property (@(posedge clk) disable iff (rst)
    (cnt <= FULL_CNT) && !(full && empty));
endmodule

// File: rtl/arx_dma_bank.sv
module arx_dma_bank #(
  parameter int W     = 16,
  parameter int SLOTS = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [$clog2(SLOTS)-1:0] wr_slot,
  input  logic [W-1:0]             wr_data,
  input  logic [$clog2(SLOTS)-1:0] rd_sel,
  output logic [W-1:0]             rd_data
);
  logic [SLOTS-1:0][W-1:0] regs;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)                                           regs[s] <= '0;
      else if (wr_en && wr_slot == ($clog2(SLOTS))'(s))  regs[s] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= regs[rd_sel];
  end

  assert_write_lands_R3: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (regs[$past(wr_slot)] == $past(wr_data)));
  assert_idle_no_change_R10: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(regs));
endmodule

// File: rtl/audio_rx_slot_buf.sv
module audio_rx_slot_buf #(
  parameter int SAMPLE_W  = 16,
  parameter int NUM_SLOTS = 4,
  parameter int DEPTH     = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         mode_wide,
  input  logic [NUM_SLOTS-1:0]         slot_dma_map,
  input  logic                         rx_full_strobe,
  input  logic [$clog2(NUM_SLOTS)-1:0] rx_slot,
  input  logic [SAMPLE_W-1:0]          rx_word,
  input  logic                         fifo_rd,
  output logic [SAMPLE_W-1:0]          fifo_rdata,
  output logic                         fifo_full,
  output logic                         fifo_empty,
  output logic                         overrun,
  input  logic                         ovr_clr,
  input  logic [$clog2(NUM_SLOTS)-1:0] dma_sel,
  output logic [SAMPLE_W-1:0]          dma_rdata
);
  import arx_pkg::*;

  logic [SAMPLE_W-1:0] sample;
  logic                to_dma, fifo_wr, drop;
  smp_mode_e           mode;

  assign mode    = smp_mode_e'(mode_wide);
  assign sample  = (mode == SMP_16BIT) ? rx_word
                 : {{(SAMPLE_W-BYTE_W){1'b0}}, rx_word[BYTE_W-1:0]};
  assign to_dma  = slot_dma_map[rx_slot];
  assign fifo_wr = rx_full_strobe && !to_dma;
  assign drop    = fifo_wr && fifo_full;

  arx_fifo #(.W(SAMPLE_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .wr_en(fifo_wr), .wr_data(sample),
    .rd_en(fifo_rd), .rd_data(fifo_rdata), .full(fifo_full), .empty(fifo_empty));

  arx_dma_bank #(.W(SAMPLE_W), .SLOTS(NUM_SLOTS)) u_dma (
    .clk(clk), .rst(rst), .wr_en(rx_full_strobe && to_dma), .wr_slot(rx_slot),
    .wr_data(sample), .rd_sel(dma_sel), .rd_data(dma_rdata));

  always_ff @(posedge clk) begin
    if (rst)          overrun <= 1'b0;
    else if (drop)    overrun <= 1'b1;
    else if (ovr_clr) overrun <= 1'b0;
  end

  assert_overrun_set_R8: assert property (@(posedge clk) disable iff (rst)
    drop |=> overrun);
  assert_overrun_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (ovr_clr && !drop) |=> !overrun);
  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (overrun && !ovr_clr) |=> overrun);
endmodule

// File: tb/audio_rx_slot_buf_tb_top.sv
module audio_rx_slot_buf_tb_top;
  localparam int DEPTH = 8;
  localparam int SLOTS = 4;

  logic clk = 0, rst = 1;
  logic mode_wide = 1, rx_full_strobe = 0, fifo_rd = 0, ovr_clr = 0;
  logic [SLOTS-1:0] slot_dma_map = '0;
  logic [1:0] rx_slot = '0, dma_sel = '0;
  logic [15:0] rx_word = '0;
  logic [15:0] fifo_rdata, dma_rdata;
  logic fifo_full, fifo_empty, overrun;

  int checks = 0, fails = 0;
  logic [15:0] expq[$];
  logic rd_fire = 0;

  always #10 clk = ~clk;

  audio_rx_slot_buf #(.SAMPLE_W(16), .NUM_SLOTS(SLOTS), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .mode_wide(mode_wide), .slot_dma_map(slot_dma_map),
    .rx_full_strobe(rx_full_strobe), .rx_slot(rx_slot), .rx_word(rx_word),
    .fifo_rd(fifo_rd), .fifo_rdata(fifo_rdata), .fifo_full(fifo_full),
    .fifo_empty(fifo_empty), .overrun(overrun), .ovr_clr(ovr_clr),
    .dma_sel(dma_sel), .dma_rdata(dma_rdata));

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Monitor: a pop seen at an edge is compared at the following falling edge.
  always @(posedge clk) rd_fire <= fifo_rd && !fifo_empty && !rst;
  always @(negedge clk) begin
    if (rd_fire) begin
      if (expq.size() == 0) chk("R5 pop with empty model", fifo_rdata, 16'hxxxx);
      else chk("R1/R5 fifo order", fifo_rdata, expq.pop_front());
    end
  end

  // Driver: strobes one word and predicts where it lands.
  task automatic push(logic [1:0] slot, logic [15:0] w, logic clr = 0);
    logic [15:0] s;
    s = mode_wide ? w : {8'h00, w[7:0]};
    rx_slot = slot; rx_word = w; rx_full_strobe = 1; ovr_clr = clr;
    if (!slot_dma_map[slot] && expq.size() < DEPTH) expq.push_back(s);
    @(negedge clk);
    rx_full_strobe = 0; ovr_clr = 0;
  endtask

  task automatic pop();
    fifo_rd = 1;
    @(negedge clk);
    fifo_rd = 0;
  endtask

  task automatic rd_dma(logic [1:0] sel, logic [15:0] exp, string req);
    dma_sel = sel;
    @(negedge clk);
    chk(req, dma_rdata, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R7 reset empty", 16'(fifo_empty), 16'd1);
    chk("R7 reset not full", 16'(fifo_full), 16'd0);
    chk("R8 reset overrun", 16'(overrun), 16'd0);
    for (int i = 0; i < SLOTS; i++) rd_dma(2'(i), 16'h0000, "R4 dma reset zero");

    // R3: DMA slots bypass the FIFO
    slot_dma_map = 4'b0101;
    push(2'd0, 16'h1111);
    push(2'd2, 16'h2222);
    chk("R3 fifo untouched", 16'(fifo_empty), 16'd1);
    rd_dma(2'd0, 16'h1111, "R3 slot0 dma");
    rd_dma(2'd2, 16'h2222, "R3 slot2 dma");
    rd_dma(2'd1, 16'h0000, "R3 slot1 dma unused");

    // R1: 16-bit FIFO path
    push(2'd1, 16'hA1B2);
    push(2'd3, 16'hC3D4);
    chk("R7 not empty", 16'(fifo_empty), 16'd0);
    pop(); pop();
    @(negedge clk);
    chk("R7 empty after drain", 16'(fifo_empty), 16'd1);
    pop();
    @(negedge clk);
    chk("R6 empty read holds data", fifo_rdata, 16'hC3D4);
    chk("R6 still empty", 16'(fifo_empty), 16'd1);

    // R2: 8-bit mode
    mode_wide = 0;
    push(2'd1, 16'hFFEE);
    push(2'd0, 16'h9988);
    rd_dma(2'd0, 16'h0088, "R2 dma high byte zero");
    pop();
    @(negedge clk);
    mode_wide = 1;

    // R10: no strobe, no store
    for (int i = 0; i < 4; i++) begin
      rx_word = 16'h5A5A ^ 16'(i); rx_slot = 2'(i);
      @(negedge clk);
    end
    chk("R10 fifo stays empty", 16'(fifo_empty), 16'd1);
    rd_dma(2'd2, 16'h2222, "R10 dma unchanged");

    // R7/R8: fill, then overflow
    for (int i = 0; i < DEPTH; i++) push(2'd3, 16'h3000 + 16'(i));
    chk("R7 full", 16'(fifo_full), 16'd1);
    chk("R8 no overrun yet", 16'(overrun), 16'd0);
    push(2'd3, 16'hDEAD);
    chk("R8 overrun set", 16'(overrun), 16'd1);
    repeat (3) @(negedge clk);
    chk("R8 overrun sticky", 16'(overrun), 16'd1);
    ovr_clr = 1; @(negedge clk); ovr_clr = 0;
    chk("R9 overrun cleared", 16'(overrun), 16'd0);
    // R9: drop together with clear, set wins
    push(2'd1, 16'hBEEF, 1'b1);
    chk("R9 set beats clear", 16'(overrun), 16'd1);
    for (int i = 0; i < DEPTH; i++) pop();
    @(negedge clk);
    chk("R7 empty after full drain", 16'(fifo_empty), 16'd1);
    chk("R8 scoreboard drained", 16'(expq.size()), 16'd0);
    ovr_clr = 1; @(negedge clk); ovr_clr = 0;
    chk("R9 final clear", 16'(overrun), 16'd0);
    finish_up();
  end
endmodule